// File: doc/BRIEF.md
# Congestion-Aware Warp Limit Controller

This block sets how many warps one GPU core may keep active. It counts three kinds of event strobes over a programmable sampling interval: memory-side congestion, network-side congestion and warp-scheduler stall cycles. At the end of each interval it sorts the memory and network totals into low, medium or high bands. From those bands it moves a registered warp limit up by one, down by one, or leaves it where it is. The limit never goes past the configured floor or the fixed ceiling.

A mode input picks between two policies. The CPU-first policy looks only at the congestion bands and so gives up GPU parallelism whenever the shared memory system is busy. The balanced policy uses the same band rule, but adds a stall-based override. When the core reports so many scheduler stalls that it can no longer hide latency, the override forces an increase. The override can only add warps, never remove them. Its trigger level is an input, so the block can be tuned to favour CPU or GPU throughput.

Top module: `warp_limit_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `warp_limit` becomes MAX_WARPS (48 by default) and the interval restarts.
- R2: Each metric's total is the number of cycles its strobe was high during the interval, including the closing cycle. A total at or above its high threshold is band HIGH. Otherwise a total below its low threshold is band LOW. Anything else is band MEDIUM.
- R3: If the memory band or the network band is HIGH, the limit goes down by one.
- R4: If both bands are LOW, the limit goes up by one.
- R5: In every other band combination the limit holds.
- R6: With `bal_mode` = 0, the stall total has no effect on the limit.
- R7: With `bal_mode` = 1 and a stall total at or above `stall_thr`, a decrease or a hold becomes an increase. The override never lowers the limit.
- R8: The limit saturates at MAX_WARPS and at `min_warps`. A `min_warps` of 0 acts as 1.
- R9: An interval lasts `intv_len` cycles (0 or 1 means every cycle). The limit changes only on the edge that closes an interval and is seen from the following cycle.
- R10: All three totals restart from zero in the first cycle of each new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bal_mode | input | 1 | 0 = CPU-first policy, 1 = balanced policy |
| mem_evt | input | 1 | Memory congestion strobe, counted per cycle |
| net_evt | input | 1 | Network congestion strobe, counted per cycle |
| stall_evt | input | 1 | Scheduler stall strobe, counted per cycle |
| mem_lo_thr | input | CNT_W | Memory total below this is LOW |
| mem_hi_thr | input | CNT_W | Memory total at or above this is HIGH |
| net_lo_thr | input | CNT_W | Network total below this is LOW |
| net_hi_thr | input | CNT_W | Network total at or above this is HIGH |
| stall_thr | input | CNT_W | Stall total that triggers the balanced override |
| intv_len | input | CNT_W | Interval length in cycles |
| min_warps | input | WARP_W | Floor for the warp limit |
| warp_limit | output | WARP_W | Registered active-warp limit |

## Verification
The bench targets the exact band edges: a total equal to the high threshold, one below the low threshold and one equal to it. A design with an off-by-one comparator would decrease or increase where it should hold. It checks that a large stall total is ignored in CPU-first mode, and that one stall below the trigger does not flip a decrease. A leaked override would raise the limit in the wrong mode. Intervals that follow a busy interval catch totals that are not cleared, which would wrongly keep the band HIGH. Runs into both saturation points, a one-cycle interval with a zero floor, and a mid-interval sample expose limits that wrap, floors that reach zero, and updates that land a cycle early.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } act_e;
endpackage

// File: rtl/wlc_interval_timer.sv
module wlc_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len,
  output logic             boundary
);
  logic [CNT_W-1:0] cyc;

  // closing cycle of the interval; lengths 0 and 1 close every cycle
  assign boundary = ({1'b0, cyc} + 1'b1) >= {1'b0, len};

  always_ff @(posedge clk) begin
    if (rst || boundary) cyc <= '0;
    else                 cyc <= cyc + 1'b1;
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (cyc == '0));
endmodule

// File: rtl/wlc_event_counter.sv
module wlc_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             clr,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, cnt} + {{CNT_W{1'b0}}, evt};
  assign total = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= total;
  end

  // R2
  grow_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt >= $past(cnt)));
  // R10
  fresh_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/wlc_level_cls.sv
module wlc_level_cls
  import wlc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] lo_thr,
  input  logic [CNT_W-1:0] hi_thr,
  output lvl_e             level
);
  always_comb begin
    if (total >= hi_thr)     level = LVL_HIGH;
    else if (total < lo_thr) level = LVL_LOW;
    else                     level = LVL_MED;
  end
endmodule

// File: rtl/wlc_decide.sv
module wlc_decide
  import wlc_pkg::*;
(
  input  lvl_e mem_lvl,
  input  lvl_e net_lvl,
  input  logic stall_hot,
  input  logic bal_mode,
  output act_e action
);
  act_e base;

  always_comb begin
    if (mem_lvl == LVL_HIGH || net_lvl == LVL_HIGH)
      base = ACT_DEC;
    else if (mem_lvl == LVL_LOW && net_lvl == LVL_LOW)
      base = ACT_INC;
    else
      base = ACT_HOLD;
  end

  always_comb begin
    if (bal_mode && stall_hot) action = ACT_INC;
    else                       action = base;
  end
endmodule

// File: rtl/warp_limit_ctrl.sv
module warp_limit_ctrl
  import wlc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_WARPS = 48,
  parameter int WARP_W    = $clog2(MAX_WARPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bal_mode,
  input  logic              mem_evt,
  input  logic              net_evt,
  input  logic              stall_evt,
  input  logic [CNT_W-1:0]  mem_lo_thr,
  input  logic [CNT_W-1:0]  mem_hi_thr,
  input  logic [CNT_W-1:0]  net_lo_thr,
  input  logic [CNT_W-1:0]  net_hi_thr,
  input  logic [CNT_W-1:0]  stall_thr,
  input  logic [CNT_W-1:0]  intv_len,
  input  logic [WARP_W-1:0] min_warps,
  output logic [WARP_W-1:0] warp_limit
);
  localparam logic [WARP_W-1:0] CEIL = WARP_W'(MAX_WARPS);
  localparam logic [WARP_W-1:0] ONE  = WARP_W'(1);

  logic             bnd;
  logic [CNT_W-1:0] mem_tot, net_tot, stall_tot;
  lvl_e             mem_lvl, net_lvl;
  logic             stall_hot;
  act_e             action;
  logic [WARP_W-1:0] floor_eff;

  wlc_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .len(intv_len), .boundary(bnd));

  wlc_event_counter #(.CNT_W(CNT_W)) u_mem_cnt (
    .clk(clk), .rst(rst), .evt(mem_evt), .clr(bnd), .total(mem_tot));
  wlc_event_counter #(.CNT_W(CNT_W)) u_net_cnt (
    .clk(clk), .rst(rst), .evt(net_evt), .clr(bnd), .total(net_tot));
  wlc_event_counter #(.CNT_W(CNT_W)) u_stall_cnt (
    .clk(clk), .rst(rst), .evt(stall_evt), .clr(bnd), .total(stall_tot));

  wlc_level_cls #(.CNT_W(CNT_W)) u_mem_cls (
    .total(mem_tot), .lo_thr(mem_lo_thr), .hi_thr(mem_hi_thr), .level(mem_lvl));
  wlc_level_cls #(.CNT_W(CNT_W)) u_net_cls (
    .total(net_tot), .lo_thr(net_lo_thr), .hi_thr(net_hi_thr), .level(net_lvl));

  assign stall_hot = (stall_tot >= stall_thr);

  wlc_decide u_decide (
    .mem_lvl(mem_lvl), .net_lvl(net_lvl), .stall_hot(stall_hot),
    .bal_mode(bal_mode), .action(action));

  always_comb begin
    if (min_warps == '0)       floor_eff = ONE;
    else if (min_warps > CEIL) floor_eff = CEIL;
    else                       floor_eff = min_warps;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warp_limit <= CEIL;
    end else if (bnd) begin
      unique case (action)
        ACT_INC:  if (warp_limit < CEIL)      warp_limit <= warp_limit + 1'b1;
        ACT_DEC:  if (warp_limit > floor_eff) warp_limit <= warp_limit - 1'b1;
        default:  ;
      endcase
    end
  end

  // R8
  range_chk: assert property (@(posedge clk) disable iff (rst)
    (warp_limit <= CEIL) && (warp_limit >= ONE));
  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(warp_limit));
  // R9
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    bnd |=> (warp_limit == $past(warp_limit)) ||
            (warp_limit == $past(warp_limit) + 1) ||
            (warp_limit + 1 == $past(warp_limit)));
  // R7
  no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bnd && bal_mode && stall_hot) |=> (warp_limit >= $past(warp_limit)));
endmodule

// File: tb/warp_limit_ctrl_test.sv
module warp_limit_ctrl_test;
  localparam int CNT_W = 16;
  localparam int WW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bal_mode = 1'b0;
  logic mem_evt = 1'b0, net_evt = 1'b0, stall_evt = 1'b0;
  logic [CNT_W-1:0] mem_lo_thr = 16'd4, mem_hi_thr = 16'd10;
  logic [CNT_W-1:0] net_lo_thr = 16'd4, net_hi_thr = 16'd10;
  logic [CNT_W-1:0] stall_thr = 16'd12, intv_len = 16'd20;
  logic [WW-1:0] min_warps = 6'd1;
  logic [WW-1:0] warp_limit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  warp_limit_ctrl uut (
    .clk(clk), .rst(rst), .bal_mode(bal_mode),
    .mem_evt(mem_evt), .net_evt(net_evt), .stall_evt(stall_evt),
    .mem_lo_thr(mem_lo_thr), .mem_hi_thr(mem_hi_thr),
    .net_lo_thr(net_lo_thr), .net_hi_thr(net_hi_thr),
    .stall_thr(stall_thr), .intv_len(intv_len),
    .min_warps(min_warps), .warp_limit(warp_limit));

  // fields: mode | mem pulses | net pulses | stall pulses | limit after interval
  localparam logic [21:0] VEC [0:13] = '{
    {1'b0, 5'd12, 5'd0,  5'd0,  6'd47},  // R3 memory high
    {1'b0, 5'd0,  5'd10, 5'd0,  6'd46},  // R3 R2 network exactly at high threshold
    {1'b0, 5'd3,  5'd3,  5'd0,  6'd47},  // R4 R10 both low, totals restarted
    {1'b0, 5'd4,  5'd0,  5'd0,  6'd47},  // R5 R2 memory exactly at low threshold
    {1'b0, 5'd9,  5'd9,  5'd0,  6'd47},  // R5 both medium
    {1'b0, 5'd0,  5'd0,  5'd0,  6'd48},  // R4
    {1'b0, 5'd0,  5'd0,  5'd0,  6'd48},  // R8 ceiling
    {1'b0, 5'd15, 5'd0,  5'd20, 6'd47},  // R6 stalls ignored
    {1'b1, 5'd15, 5'd0,  5'd20, 6'd48},  // R7 override raises
    {1'b1, 5'd15, 5'd0,  5'd11, 6'd47},  // R7 one below trigger
    {1'b1, 5'd15, 5'd0,  5'd12, 6'd48},  // R7 at trigger
    {1'b1, 5'd20, 5'd0,  5'd0,  6'd47},  // R3 balanced without override
    {1'b1, 5'd5,  5'd0,  5'd12, 6'd48},  // R7 hold turned into increase
    {1'b1, 5'd0,  5'd0,  5'd0,  6'd48}   // R8 ceiling in balanced mode
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s warp_limit actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the closing edge
  task automatic run_interval(input int len, input int m, input int n, input int s);
    for (int i = 0; i < len; i++) begin
      mem_evt   = (i < m);
      net_evt   = (i < n);
      stall_evt = (i < s);
      @(negedge clk);
    end
    mem_evt = 1'b0; net_evt = 1'b0; stall_evt = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset", int'(warp_limit), 48);

    for (int k = 0; k < 14; k++) begin
      bal_mode = VEC[k][21];
      run_interval(20, int'(VEC[k][20:16]), int'(VEC[k][15:11]), int'(VEC[k][10:6]));
      check($sformatf("table row %0d", k), int'(warp_limit), int'(VEC[k][5:0]));
    end

    // R8 floor from min_warps
    bal_mode = 1'b0;
    min_warps = 6'd46;
    run_interval(20, 20, 0, 0);
    check("R8 floor step 1", int'(warp_limit), 47);
    run_interval(20, 20, 0, 0);
    check("R8 floor step 2", int'(warp_limit), 46);
    run_interval(20, 20, 0, 0);
    check("R8 floor held", int'(warp_limit), 46);

    // R1 reset in the middle of a run
    run_interval(7, 7, 0, 0);
    do_reset();
    check("R1 mid-run reset", int'(warp_limit), 48);

    // R9 R8 one-cycle intervals with a zero floor
    min_warps = 6'd0;
    intv_len = 16'd1;
    mem_hi_thr = 16'd1;
    for (int k = 0; k < 60; k++) run_interval(1, 1, 0, 0);
    check("R8 zero floor acts as one", int'(warp_limit), 1);
    run_interval(1, 0, 0, 0);
    check("R9 single-cycle interval rise", int'(warp_limit), 2);

    // R9 update lands only after the closing edge
    do_reset();
    intv_len = 16'd5;
    mem_hi_thr = 16'd5;
    run_interval(4, 4, 0, 0);
    check("R9 unchanged inside interval", int'(warp_limit), 48);
    run_interval(1, 1, 0, 0);
    check("R9 R3 change after closing edge", int'(warp_limit), 47);
    run_interval(5, 0, 0, 0);
    check("R10 R4 fresh interval rises", int'(warp_limit), 48);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule